// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block turns single transfers from an internal bus into strobe sequences for a DRAM with a multiplexed address bus. It keeps track of which row is open. A transfer that lands in that row skips the precharge and row states and runs only a column cycle. A transfer to any other row first releases RAS for one precharge state, then presents the new row and runs the column cycle. Every bus state lasts a fixed number of ticks of a base clock enable, 20 by default.

A mode input decides what RAS does while the bus serves another address area, which the `other_busy_i` input signals. With the mode set, RAS stays low and the open row survives. With it clear, RAS is released and the next transfer runs in full. Changing the requesting master, shown by the DMA flag, does not close the row. Each of the four transfer classes (CPU or DMA, read or write) picks either a two-state long-pitch column cycle or a one-state short-pitch column cycle. In the short-pitch cycle, CAS stays high for the first part of the state, and a duty input sets that part to 50% or 35%. A low wait input stretches the final column state.

Top module: `dram_page_seq`

## Requirements
- R1: While rst_ni is low, dram_ras_no, dram_cas_no and dram_we_no are high, and dram_dq_oe_o and req_ready_o are low.
- R2: A transfer while no row is open, or to a row other than the open one, runs precharge, then row, then column states. RAS falls exactly once, with the row (address bits above the column field) on dram_addr_o. If a different row was open, RAS is high for exactly one bus state before that fall.
- R3: A transfer to the open row causes no RAS transition and runs only the column states. This holds even when req_dma_i differs from the previous transfer. CAS is only ever low while RAS is low.
- R4: long_pitch_i bit index {req_dma_i, req_we_i} selects the cycle: bit0 CPU read, bit1 CPU write, bit2 DMA read, bit3 DMA write. When the bit is 1, CAS is low for two full states.
- R5: When the selected bit is 0, there is one column state. CAS is high for its first 10 ticks with cas_duty_i=0, or its first 7 ticks with cas_duty_i=1, and low for the rest of the state.
- R6: wait_ni sampled low on the last tick of the final column state repeats that state with CAS low throughout. A low sampled at the end of the first long-pitch state has no effect.
- R7: For a write, dram_we_no is low and dram_dq_oe_o is high over every column state, including repeats. dram_dq_o carries req_wdata_i, and the first CAS-low cycle shows the column (low address bits) on dram_addr_o.
- R8: For a read, dram_dq_i is captured on the last tick of the final column state and shown on rsp_rdata_o during the req_ready_o pulse.
- R9: With ras_hold_i=1, other_busy_i leaves RAS low, and the row stays open for a later hit.
- R10: With ras_hold_i=0, other_busy_i seen while idle raises RAS on the next cycle, and the next transfer runs in full.
- R11: State lengths count tick_en_i pulses, not clock cycles.
- R12: Each transfer ends with req_ready_o high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Base timing tick enable |
| ras_hold_i | input | 1 | 1: keep RAS low while other areas are served |
| cas_duty_i | input | 1 | Short-pitch CAS high time: 0 gives 50%, 1 gives 35% |
| long_pitch_i | input | 4 | Per-class long-pitch enable, indexed {dma, we} |
| other_busy_i | input | 1 | Bus is serving another address area |
| req_valid_i | input | 1 | Transfer request |
| req_addr_i | input | ROW_W+COL_W | Transfer address, row above column |
| req_we_i | input | 1 | Write transfer |
| req_dma_i | input | 1 | Request comes from the DMA master |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data |
| wait_ni | input | 1 | Active-low wait request |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write strobe, active low |
| dram_dq_o | output | DATA_W | Write data to DRAM |
| dram_dq_oe_o | output | 1 | Data bus drive enable |
| dram_dq_i | input | DATA_W | Read data from DRAM |

## Verification
Two things can land on the same tick edge: the wait sample and the end of the final column state, where read capture and the ready pulse happen. The bench holds wait low across one, two or no such edges while sweeping every transfer class, pitch and duty setting. It judges the outcome by the total CAS-low time, the write-strobe time and the read data returned with the pulse. A second collision is a wait low at the end of the first long-pitch state. This must not stretch anything, and the bench checks it by the same CAS-low count.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL1,
    ST_COL2,
    ST_COLS
  } bus_st_e;
endpackage

// File: rtl/dram_tick_gen.sv
module dram_tick_gen #(
  parameter int unsigned TICKS = 20,
  localparam int unsigned CW = $clog2(TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  output logic [CW-1:0] tick_o,
  output logic          bnd_o
);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(TICKS - 1));
  assign tick_o = cnt_q;
  assign bnd_o  = tick_en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_en_i) cnt_q <= last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] set_row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             open_o,
  output logic             hit_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (clr_i) begin
      open_q <= 1'b0;
    end else if (set_i) begin
      open_q <= 1'b1;
      row_q  <= set_row_i;
    end
  end

  assign open_o = open_q;
  assign hit_o  = open_q && (row_q == cmp_row_i);
endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
  import dram_seq_pkg::*;
#(
  parameter int unsigned TICKS = 20,
  localparam int unsigned CW    = $clog2(TICKS),
  localparam int unsigned HI_50 = TICKS / 2,
  localparam int unsigned HI_35 = (TICKS * 7) / 20
) (
  input  bus_st_e       st_i,
  input  logic          we_i,
  input  logic          rep_i,
  input  logic          duty_i,
  input  logic [CW-1:0] tick_i,
  output logic          cas_no,
  output logic          we_no,
  output logic          oe_o,
  output logic          row_sel_o
);
  logic          col_st;
  logic [CW-1:0] hi_ticks;

  assign col_st    = (st_i == ST_COL1) || (st_i == ST_COL2) || (st_i == ST_COLS);
  assign hi_ticks  = duty_i ? CW'(HI_35) : CW'(HI_50);
  assign row_sel_o = (st_i == ST_PRE) || (st_i == ST_ROW);
  assign oe_o      = col_st && we_i;
  assign we_no     = !(col_st && we_i);

  always_comb begin
    cas_no = 1'b1;
    if (st_i == ST_COL1 || st_i == ST_COL2) cas_no = 1'b0;
    else if (st_i == ST_COLS) cas_no = !rep_i && (tick_i < hi_ticks);
  end
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TICKS  = 20,
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              ras_hold_i,
  input  logic              cas_duty_i,
  input  logic [3:0]        long_pitch_i,
  input  logic              other_busy_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic              req_dma_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              wait_ni,
  output logic [MUX_W-1:0]  dram_addr_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  localparam int unsigned CW = $clog2(TICKS);

  bus_st_e           st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q, lp_q, rep_q, ready_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [CW-1:0]     tick;
  logic              bnd, row_open, row_hit, in_idle, start, release_ras, lp_sel, row_sel;

  dram_tick_gen #(.TICKS(TICKS)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_en_i(tick_en_i),
    .tick_o   (tick),
    .bnd_o    (bnd)
  );

  assign in_idle     = (st_q == ST_IDLE);
  assign start       = in_idle && bnd && req_valid_i && !other_busy_i;
  assign release_ras = in_idle && other_busy_i && !ras_hold_i;
  assign lp_sel      = long_pitch_i[{req_dma_i, req_we_i}];

  dram_row_tracker #(.ROW_W(ROW_W)) u_row (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    ((st_q == ST_PRE) && bnd),
    .clr_i    ((start && !row_hit) || release_ras),
    .set_row_i(addr_q[ADDR_W-1:COL_W]),
    .cmp_row_i(req_addr_i[ADDR_W-1:COL_W]),
    .open_o   (row_open),
    .hit_o    (row_hit)
  );

  dram_strobe_gen #(.TICKS(TICKS)) u_strb (
    .st_i     (st_q),
    .we_i     (we_q),
    .rep_i    (rep_q),
    .duty_i   (cas_duty_i),
    .tick_i   (tick),
    .cas_no   (dram_cas_no),
    .we_no    (dram_we_no),
    .oe_o     (dram_dq_oe_o),
    .row_sel_o(row_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      lp_q    <= 1'b0;
      rep_q   <= 1'b0;
      ready_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ready_q <= 1'b0;
      if (bnd) begin
        unique case (st_q)
          ST_IDLE: if (start) begin
            addr_q  <= req_addr_i;
            we_q    <= req_we_i;
            wdata_q <= req_wdata_i;
            lp_q    <= lp_sel;
            rep_q   <= 1'b0;
            st_q    <= row_hit ? (lp_sel ? ST_COL1 : ST_COLS) : ST_PRE;
          end
          ST_PRE:  st_q <= ST_ROW;
          ST_ROW:  st_q <= lp_q ? ST_COL1 : ST_COLS;
          ST_COL1: st_q <= ST_COL2;
          ST_COL2, ST_COLS: begin
            if (!wait_ni) begin
              rep_q <= 1'b1;
            end else begin
              st_q    <= ST_IDLE;
              rep_q   <= 1'b0;
              ready_q <= 1'b1;
              if (!we_q) rdata_q <= dram_dq_i;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign dram_ras_no = !row_open;
  assign dram_addr_o = row_sel ? MUX_W'(addr_q[ADDR_W-1:COL_W]) : MUX_W'(addr_q[COL_W-1:0]);
  assign dram_dq_o   = wdata_q;
  assign req_ready_o = ready_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_hold_i,
  input logic other_busy_i,
  input logic idle_i,
  input logic ras_ni,
  input logic cas_ni,
  input logic we_ni,
  input logic oe_i,
  input logic ready_i
);
  assert_cas_inside_ras_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_ni |-> !ras_ni);

  assert_write_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> (oe_i && !ras_ni));

  assert_ready_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> !ready_i);

  assert_ready_after_col_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> $past(!cas_ni));

  assert_hold_ras_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_hold_i && other_busy_i && !ras_ni) |=> !ras_ni);

  assert_release_ras_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && other_busy_i && !ras_hold_i) |=> ras_ni);
endmodule

bind dram_page_seq dram_page_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ras_hold_i  (ras_hold_i),
  .other_busy_i(other_busy_i),
  .idle_i      (in_idle),
  .ras_ni      (dram_ras_no),
  .cas_ni      (dram_cas_no),
  .we_ni       (dram_we_no),
  .oe_i        (dram_dq_oe_o),
  .ready_i     (req_ready_o)
);

// File: tb/dram_page_seq_tb.sv
`timescale 1ns/1ps
module dram_page_seq_tb;
  localparam int T = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick_en = 1'b1, ras_hold = 1'b1, cas_duty = 1'b0, other_busy = 1'b0;
  logic [3:0]  lp_mask = 4'hF;
  logic        req_valid = 1'b0, req_we = 1'b0, req_dma = 1'b0, wait_n = 1'b1;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, ras_n, cas_n, we_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [7:0]  dram_addr;
  logic [7:0]  mem_row = '0;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  exp_open = 1'b0;
  logic [7:0] exp_row = '0;

  always #4 clk = ~clk;

  assign dq_i = {mem_row, dram_addr} ^ 16'h5A3C;

  dram_page_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .ras_hold_i(ras_hold),
    .cas_duty_i(cas_duty), .long_pitch_i(lp_mask), .other_busy_i(other_busy),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_we_i(req_we),
    .req_dma_i(req_dma), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_rdata_o(rdata), .wait_ni(wait_n), .dram_addr_o(dram_addr),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // one transfer; waits: repeats of final column state; tc1_wait: wait low at end of Tc1 only
  task automatic access(input logic [7:0] row, input logic [7:0] col, input bit we,
                        input bit dma, input logic [15:0] wd, input int waits,
                        input bit tc1_wait, input int rate);
    bit lp, hit, prev_ras, got;
    int hi, base, wlim, n_fall, n_rhigh, n_cas, n_we;
    logic [7:0]  a_fall, a_cas;
    logic [15:0] d_we, rd;
    lp   = lp_mask[{dma, we}];
    hi   = cas_duty ? 7 : 10;
    base = lp ? 2 * T : T - hi;
    wlim = (waits > 0) ? base + T * waits - T / 2 : (tc1_wait ? T + T / 2 : 0);
    hit  = exp_open && (row == exp_row);
    n_fall = 0; n_rhigh = 0; n_cas = 0; n_we = 0; got = 0;
    a_fall = '0; a_cas = '0; d_we = '0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {row, col}; req_we = we; req_dma = dma; req_wdata = wd;
    prev_ras = ras_n;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (rate == 2) tick_en = !tick_en;
      if (ras_n) n_rhigh++;
      if (prev_ras && !ras_n) begin
        n_fall++; a_fall = dram_addr; mem_row = dram_addr;
      end
      prev_ras = ras_n;
      if (!cas_n) begin
        if (n_cas == 0) a_cas = dram_addr;
        n_cas++;
      end
      if (!we_n) begin
        if (n_we == 0) d_we = dq_o;
        n_we++;
      end
      wait_n = !(n_cas < wlim);
      if (req_ready) begin
        got = 1; rd = rdata; break;
      end
    end
    req_valid = 1'b0; wait_n = 1'b1; tick_en = 1'b1;
    chk(got, "R12 ready seen", got, 1);
    chk(n_fall == (hit ? 0 : 1), hit ? "R3 hit no RAS fall" : "R2 miss one RAS fall",
        n_fall, hit ? 0 : 1);
    if (!hit) chk(a_fall == row, "R2 row address at RAS fall", a_fall, row);
    if (!hit && exp_open) chk(n_rhigh == rate * T, "R2 precharge one state", n_rhigh, rate * T);
    chk(a_cas == col, "R7 column address at CAS", a_cas, col);
    chk(n_cas == rate * (base + T * waits),
        lp ? "R4/R6/R11 long CAS time" : "R5/R6/R11 short CAS time",
        n_cas, rate * (base + T * waits));
    if (we) begin
      chk(n_we == rate * ((lp ? 2 * T : T) + T * waits), "R7 write strobe time",
          n_we, rate * ((lp ? 2 * T : T) + T * waits));
      chk(d_we == wd, "R7 write data", d_we, wd);
    end else begin
      chk(n_we == 0, "R7 no write strobe on read", n_we, 0);
      chk(rd == ({row, col} ^ 16'h5A3C), "R8 read data", rd, {row, col} ^ 16'h5A3C);
    end
    @(negedge clk);
    chk(!req_ready, "R12 single-cycle ready", req_ready, 0);
    exp_open = 1'b1; exp_row = row;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int nh;
    logic [7:0] r;
    repeat (4) @(negedge clk);
    chk(ras_n, "R1 reset ras", ras_n, 1);
    chk(cas_n, "R1 reset cas", cas_n, 1);
    chk(we_n, "R1 reset we", we_n, 1);
    chk(!dq_oe, "R1 reset oe", dq_oe, 0);
    chk(!req_ready, "R1 reset ready", req_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    access(8'h03, 8'h05, 0, 0, 16'h0, 0, 0, 1);      // R2 closed row
    access(8'h03, 8'h09, 1, 1, 16'hBEEF, 0, 0, 1);   // R3 hit, master changed
    access(8'h04, 8'h11, 0, 0, 16'h0, 0, 0, 1);      // R2 miss with open row
    access(8'h04, 8'h12, 0, 0, 16'h0, 0, 1, 1);      // R6 wait at Tc1 ignored
    access(8'h05, 8'h13, 1, 0, 16'h1234, 0, 0, 2);   // R11 half-rate ticks
    lp_mask = 4'h0;
    access(8'h05, 8'h14, 0, 1, 16'h0, 0, 0, 2);      // R11 short pitch half rate

    for (int m = 0; m < 4; m++) begin
      lp_mask = (m == 0) ? 4'h0 : (m == 1) ? 4'hF : (m == 2) ? 4'h6 : 4'h9;
      for (int cls = 0; cls < 4; cls++)
        for (int w = 0; w < 3; w++)
          for (int d = 0; d < 2; d++) begin
            cas_duty = d[0];
            r = (((cls + w + d) % 2) == 0) ? exp_row + 8'd1 : exp_row;
            access(r, {m[1:0], cls[1:0], w[1:0], d[0], 1'b1}, cls[0], cls[1],
                   {m[3:0], cls[3:0], w[3:0], d[3:0]} ^ 16'hA5F0, w, 0, 1);
          end
    end

    ras_hold = 1'b1; lp_mask = 4'hF; cas_duty = 1'b0;
    access(8'h09, 8'h01, 0, 0, 16'h0, 0, 0, 1);
    other_busy = 1'b1; nh = 0;
    repeat (45) begin
      @(negedge clk);
      if (ras_n) nh++;
    end
    other_busy = 1'b0;
    chk(nh == 0, "R9 RAS held during other area", nh, 0);
    access(8'h09, 8'h02, 1, 1, 16'h7777, 0, 0, 1);   // R9 still a hit

    ras_hold = 1'b0;
    @(negedge clk);
    other_busy = 1'b1;
    @(negedge clk);
    chk(ras_n, "R10 RAS released on other area", ras_n, 1);
    repeat (3) @(negedge clk);
    other_busy = 1'b0;
    exp_open = 1'b0;
    access(8'h09, 8'h03, 0, 0, 16'h0, 0, 0, 1);      // R10 full access again

    done = 1'b1;
    summary();
    $finish;
  end
endmodule